// File: doc/BRIEF.md
# DMA Mailbox Strobe Decoder

This block sits on the slave side of a DMA mailbox. It watches the asynchronous bus strobes that an external DMA controller drives, works out whether each access is a mailbox read or a mailbox write, and gives the mailbox one clean single-cycle pulse per access. It accepts two strobe conventions. In the split-strobe convention there are separate read and write strobes qualified by a channel acknowledge. In the direction-plus-strobe convention a direction line is qualified by the acknowledge and a data strobe. A static input picks the convention.

The block also drives one transfer request line for each direction. A request is raised only when the mailbox is ready for that direction and the transfer count for that direction is not used up. For DMA controllers that trigger on edges, an edge-request mode removes the request from the start of each matching access until its end. Every access then produces a fresh request edge. All strobes pass through a two-flop synchronizer before they are decoded. The mailbox storage and the timing of fly-by transfers are handled outside this block.

Top module: `dma_strobe_decoder`

## Requirements
- R1: With `bus_mode`=0, an access where `chan_ack_n`=0 and `rd_strobe_n`=0 gives one high cycle on `mbox_rd`. The pulse appears at the third rising clock edge after the strobes settle.
- R2: With `bus_mode`=0, an access where `chan_ack_n`=0 and `wr_strobe_n`=0 gives one high cycle on `mbox_wr`, with the same latency as R1.
- R3: With `bus_mode`=1, an access where `chan_ack_n`=0, `data_strobe_n`=0 and `dir_is_read`=1 gives one `mbox_rd` pulse, with the same latency as R1.
- R4: With `bus_mode`=1, an access where `chan_ack_n`=0, `data_strobe_n`=0 and `dir_is_read`=0 gives one `mbox_wr` pulse, with the same latency as R1.
- R5: An access that is held for many cycles gives exactly one pulse. After the pulse the output stays low until the access ends and a new one starts.
- R6: No pulse results when `chan_ack_n`=1. The strobes of the convention that is not selected are also ignored: with `bus_mode`=0, `data_strobe_n` and `dir_is_read` have no effect, and with `bus_mode`=1, `rd_strobe_n` and `wr_strobe_n` have no effect.
- R7: With `edge_req_en`=0, `xfer_req_tx` equals `tx_space` AND (`tx_left`≠0) in the same cycle, even while a write access is in progress.
- R8: With `edge_req_en`=0, `xfer_req_rx` equals `rx_avail` AND (`rx_left`≠0) in the same cycle, even while a read access is in progress.
- R9: With `edge_req_en`=1, `xfer_req_tx` goes low at the same edge as the `mbox_wr` pulse and stays low while the write access lasts. It is allowed again at the third rising edge after the access ends.
- R10: With `edge_req_en`=1, `xfer_req_rx` is removed and re-allowed in the same way around a read access. The request for the other direction is not affected.
- R11: While `rst_n`=0, both pulses are low and any edge-mode withdrawal is cleared. The requests then follow only the ready and count inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode | input | 1 | Static: 0 = split read/write strobes, 1 = direction plus data strobe |
| edge_req_en | input | 1 | Static: 1 = withdraw each request for the duration of each matching access |
| chan_ack_n | input | 1 | Channel acknowledge from the DMA controller, active low, asynchronous |
| rd_strobe_n | input | 1 | Read strobe (split mode), active low, asynchronous |
| wr_strobe_n | input | 1 | Write strobe (split mode), active low, asynchronous |
| dir_is_read | input | 1 | Direction (strobe mode): 1 = read, 0 = write, asynchronous |
| data_strobe_n | input | 1 | Data strobe (strobe mode), active low, asynchronous |
| tx_space | input | 1 | Mailbox can accept a write (synchronous) |
| rx_avail | input | 1 | Mailbox holds data to read (synchronous) |
| tx_left | input | CNT_W | Remaining transmit transfers |
| rx_left | input | CNT_W | Remaining receive transfers |
| mbox_rd | output | 1 | Single-cycle mailbox read pulse |
| mbox_wr | output | 1 | Single-cycle mailbox write pulse |
| xfer_req_tx | output | 1 | Transmit-direction transfer request |
| xfer_req_rx | output | 1 | Receive-direction transfer request |

## Verification
A strobe change is made mid-cycle. It reaches the pulse outputs and the edge-mode request withdrawal at the third rising edge: two synchronizer stages and one output register. The bench therefore samples at the falling edge after that third edge. It also checks the sample one cycle earlier, so that a pulse arriving early is caught, and the sample one cycle later, so that a pulse lasting too long is caught. The request outputs depend combinationally on the ready and count inputs, so the level-mode checks sample a short delay after those inputs change. The check on a request coming back after an access uses the same three-edge count, measured from the end of the access.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

  typedef enum logic {
    BUS_SPLIT = 1'b0,
    BUS_DIRDS = 1'b1
  } bus_mode_e;

  // Synchronized strobe bundle, order {ack_n, rd_n, wr_n, dir_rd, ds_n}
  localparam int STB_W = 5;
  localparam logic [STB_W-1:0] STB_IDLE = 5'b11111;

  function automatic logic is_rd_access(bus_mode_e m, logic ack_n, logic rd_n,
                                        logic dir_rd, logic ds_n);
    if (m == BUS_SPLIT) return !ack_n && !rd_n;
    return !ack_n && !ds_n && dir_rd;
  endfunction

  function automatic logic is_wr_access(bus_mode_e m, logic ack_n, logic wr_n,
                                        logic dir_rd, logic ds_n);
    if (m == BUS_SPLIT) return !ack_n && !wr_n;
    return !ack_n && !ds_n && !dir_rd;
  endfunction

endpackage

// File: rtl/dsd_sync.sv
module dsd_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int NS = (STAGES < 2) ? 2 : STAGES;

  logic [NS-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {NS{RST_VAL}};
    else        chain <= {chain[NS-2:0], d};
  end

  assign q = chain[NS-1];
endmodule

// File: rtl/dsd_decode.sv
module dsd_decode
  import dsd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  bus_mode_e        mode,
  input  logic [STB_W-1:0] stb,
  output logic             rd_start,
  output logic             rd_end,
  output logic             wr_start,
  output logic             wr_end,
  output logic             rd_pulse,
  output logic             wr_pulse
);
  logic ack_n, rd_n, wr_n, dir_rd, ds_n;
  logic rd_act, wr_act, rd_prev, wr_prev;

  assign {ack_n, rd_n, wr_n, dir_rd, ds_n} = stb;
  assign rd_act = is_rd_access(mode, ack_n, rd_n, dir_rd, ds_n);
  assign wr_act = is_wr_access(mode, ack_n, wr_n, dir_rd, ds_n);

  assign rd_start = rd_act && !rd_prev;
  assign rd_end   = !rd_act && rd_prev;
  assign wr_start = wr_act && !wr_prev;
  assign wr_end   = !wr_act && wr_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev  <= 1'b0;
      wr_prev  <= 1'b0;
      rd_pulse <= 1'b0;
      wr_pulse <= 1'b0;
    end else begin
      rd_prev  <= rd_act;
      wr_prev  <= wr_act;
      rd_pulse <= rd_start;
      wr_pulse <= wr_start;
    end
  end

  // R5: one pulse per access
  a_r5_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pulse |=> !rd_pulse);
  a_r5_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);
endmodule

// File: rtl/dsd_req.sv
module dsd_req #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_mode,
  input  logic             acc_start,
  input  logic             acc_end,
  input  logic             ready,
  input  logic [CNT_W-1:0] left,
  output logic             hold,
  output logic             dreq
);
  function automatic logic count_live(logic [CNT_W-1:0] c);
    return |c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hold <= 1'b0;
    else if (acc_start) hold <= 1'b1;
    else if (acc_end)   hold <= 1'b0;
  end

  assign dreq = ready && count_live(left) && !(edge_mode && hold);

  // R7/R8: never request without readiness and remaining count
  a_r7_req_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    dreq |-> (ready && left != '0));
  // R9/R10: withdrawal only begins at an access start
  a_r9_hold_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> $past(acc_start));
endmodule

// File: rtl/dma_strobe_decoder.sv
module dma_strobe_decoder
  import dsd_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_mode,
  input  logic             edge_req_en,
  input  logic             chan_ack_n,
  input  logic             rd_strobe_n,
  input  logic             wr_strobe_n,
  input  logic             dir_is_read,
  input  logic             data_strobe_n,
  input  logic             tx_space,
  input  logic             rx_avail,
  input  logic [CNT_W-1:0] tx_left,
  input  logic [CNT_W-1:0] rx_left,
  output logic             mbox_rd,
  output logic             mbox_wr,
  output logic             xfer_req_tx,
  output logic             xfer_req_rx
);
  localparam int NDIR = 2;  // index 0 = transmit (writes), 1 = receive (reads)

  logic [STB_W-1:0] stb_sync;
  logic rd_start, rd_end, wr_start, wr_end;
  logic [NDIR-1:0] dir_start, dir_end, dir_ready, dir_hold, dir_req;
  logic [NDIR-1:0][CNT_W-1:0] dir_left;

  dsd_sync #(.W(STB_W), .STAGES(SYNC_STAGES), .RST_VAL(STB_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({chan_ack_n, rd_strobe_n, wr_strobe_n, dir_is_read, data_strobe_n}),
    .q(stb_sync)
  );

  dsd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .mode(bus_mode_e'(bus_mode)), .stb(stb_sync),
    .rd_start(rd_start), .rd_end(rd_end), .wr_start(wr_start), .wr_end(wr_end),
    .rd_pulse(mbox_rd), .wr_pulse(mbox_wr)
  );

  assign dir_start = {rd_start, wr_start};
  assign dir_end   = {rd_end, wr_end};
  assign dir_ready = {rx_avail, tx_space};
  assign dir_left  = {rx_left, tx_left};

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    dsd_req #(.CNT_W(CNT_W)) u_req (
      .clk(clk), .rst_n(rst_n), .edge_mode(edge_req_en),
      .acc_start(dir_start[g]), .acc_end(dir_end[g]),
      .ready(dir_ready[g]), .left(dir_left[g]),
      .hold(dir_hold[g]), .dreq(dir_req[g])
    );
  end

  assign xfer_req_tx = dir_req[0];
  assign xfer_req_rx = dir_req[1];

  // R9: the write pulse coincides with the transmit withdrawal
  a_r9_tx_withdrawn: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_req_en && mbox_wr) |-> !xfer_req_tx);
  // R10: the read pulse coincides with the receive withdrawal
  a_r10_rx_withdrawn: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_req_en && mbox_rd) |-> !xfer_req_rx);
  // R5/R6: the two pulses come from exclusive decodes in strobe mode
  a_r6_dirds_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mode |-> !(mbox_rd && mbox_wr));
endmodule

// File: tb/dma_strobe_decoder_test.sv
module dma_strobe_decoder_test;
  localparam int CNT_W = 4;
  localparam int NVEC = 10;
  // {mode, ack_n, rd_n, wr_n, dir_rd, ds_n, exp_rd, exp_wr}
  localparam logic [7:0] VECS [NVEC] = '{
    8'b0_0_0_1_1_1_1_0,  // R1 split read
    8'b0_0_1_0_1_1_0_1,  // R2 split write
    8'b0_1_0_1_1_1_0_0,  // R6 no ack
    8'b0_0_1_1_1_0_0_0,  // R6 ds ignored in split mode
    8'b0_0_1_1_0_0_0_0,  // R6 ds/dir ignored in split mode
    8'b1_0_1_1_1_0_1_0,  // R3 strobe-mode read
    8'b1_0_1_1_0_0_0_1,  // R4 strobe-mode write
    8'b1_0_0_1_1_1_0_0,  // R6 rd strobe ignored in strobe mode
    8'b1_0_1_0_0_1_0_0,  // R6 wr strobe ignored in strobe mode
    8'b1_1_1_1_1_0_0_0   // R6 no ack
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_mode = 1'b0, edge_req_en = 1'b0;
  logic chan_ack_n = 1'b1, rd_strobe_n = 1'b1, wr_strobe_n = 1'b1;
  logic dir_is_read = 1'b1, data_strobe_n = 1'b1;
  logic tx_space = 1'b0, rx_avail = 1'b0;
  logic [CNT_W-1:0] tx_left = '0, rx_left = '0;
  logic mbox_rd, mbox_wr, xfer_req_tx, xfer_req_rx;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dma_strobe_decoder #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .edge_req_en(edge_req_en),
    .chan_ack_n(chan_ack_n), .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n),
    .dir_is_read(dir_is_read), .data_strobe_n(data_strobe_n),
    .tx_space(tx_space), .rx_avail(rx_avail), .tx_left(tx_left), .rx_left(rx_left),
    .mbox_rd(mbox_rd), .mbox_wr(mbox_wr),
    .xfer_req_tx(xfer_req_tx), .xfer_req_rx(xfer_req_rx)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    chan_ack_n = 1'b1; rd_strobe_n = 1'b1; wr_strobe_n = 1'b1;
    dir_is_read = 1'b1; data_strobe_n = 1'b1;
  endtask

  task automatic wait_neg(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic exp_req(logic rdy, logic [CNT_W-1:0] left);
    return rdy && (left != 0);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      finish_run();
    end
  end

  initial begin
    // R11: reset state
    wait_neg(2);
    tx_space = 1'b1; tx_left = 4'd2;
    #1;
    chk("R11 pulses in reset", {6'b0, mbox_rd, mbox_wr}, 8'h00);
    chk("R11 tx req in reset", {7'b0, xfer_req_tx}, {7'b0, exp_req(1'b1, 4'd2)});
    tx_space = 1'b0; tx_left = '0;
    @(negedge clk) rst_n = 1'b1;
    wait_neg(3);

    // R1-R6: vector walk
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] e;
      e = VECS[v];
      bus_mode = e[7];
      wait_neg(1);
      chan_ack_n = e[6]; rd_strobe_n = e[5]; wr_strobe_n = e[4];
      dir_is_read = e[3]; data_strobe_n = e[2];
      wait_neg(2);
      chk($sformatf("R5 early vec%0d", v), {6'b0, mbox_rd, mbox_wr}, 8'h00);
      wait_neg(1);
      chk($sformatf("R1/R2/R3/R4/R6 vec%0d", v), {6'b0, mbox_rd, mbox_wr}, {6'b0, e[1:0]});
      wait_neg(1);
      chk($sformatf("R5 single vec%0d", v), {6'b0, mbox_rd, mbox_wr}, 8'h00);
      wait_neg(4);
      chk($sformatf("R5 held vec%0d", v), {6'b0, mbox_rd, mbox_wr}, 8'h00);
      idle();
      wait_neg(5);
    end

    // R7/R8: level request mode
    edge_req_en = 1'b0; bus_mode = 1'b0;
    tx_space = 1'b1; tx_left = 4'd3; rx_avail = 1'b1; rx_left = 4'd1;
    #1;
    chk("R7 tx ready", {7'b0, xfer_req_tx}, {7'b0, exp_req(tx_space, tx_left)});
    chk("R8 rx ready", {7'b0, xfer_req_rx}, {7'b0, exp_req(rx_avail, rx_left)});
    tx_left = 4'd0; rx_avail = 1'b0;
    #1;
    chk("R7 tx count used up", {7'b0, xfer_req_tx}, 8'h00);
    chk("R8 rx not available", {7'b0, xfer_req_rx}, 8'h00);
    tx_left = 4'd5; tx_space = 1'b0; rx_avail = 1'b1; rx_left = 4'd0;
    #1;
    chk("R7 tx no space", {7'b0, xfer_req_tx}, 8'h00);
    chk("R8 rx count used up", {7'b0, xfer_req_rx}, 8'h00);
    tx_space = 1'b1; rx_left = 4'd8;
    wait_neg(1);
    chan_ack_n = 1'b0; wr_strobe_n = 1'b0;
    wait_neg(4);
    chk("R7 no gating during write", {7'b0, xfer_req_tx}, 8'h01);
    idle(); chan_ack_n = 1'b0; rd_strobe_n = 1'b0;
    wait_neg(4);
    chk("R8 no gating during read", {7'b0, xfer_req_rx}, 8'h01);
    idle();
    wait_neg(5);

    // R9: edge mode, transmit withdrawal around a write
    edge_req_en = 1'b1;
    wait_neg(1);
    chan_ack_n = 1'b0; wr_strobe_n = 1'b0;
    wait_neg(2);
    chk("R9 tx still up before edge 3", {7'b0, xfer_req_tx}, 8'h01);
    wait_neg(1);
    chk("R9 tx withdrawn with pulse", {6'b0, mbox_wr, xfer_req_tx}, 8'h02);
    chk("R10 rx unaffected by write", {7'b0, xfer_req_rx}, 8'h01);
    wait_neg(5);
    chk("R9 tx stays withdrawn", {7'b0, xfer_req_tx}, 8'h00);
    idle();
    wait_neg(2);
    chk("R9 tx not back before edge 3", {7'b0, xfer_req_tx}, 8'h00);
    wait_neg(1);
    chk("R9 tx re-allowed", {7'b0, xfer_req_tx}, 8'h01);

    // R10: edge mode, receive withdrawal around a strobe-mode read
    bus_mode = 1'b1;
    wait_neg(1);
    chan_ack_n = 1'b0; dir_is_read = 1'b1; data_strobe_n = 1'b0;
    wait_neg(2);
    chk("R10 rx still up before edge 3", {7'b0, xfer_req_rx}, 8'h01);
    wait_neg(1);
    chk("R10 rx withdrawn with pulse", {6'b0, mbox_rd, xfer_req_rx}, 8'h02);
    chk("R10 tx unaffected by read", {7'b0, xfer_req_tx}, 8'h01);
    idle();
    wait_neg(2);
    chk("R10 rx not back before edge 3", {7'b0, xfer_req_rx}, 8'h00);
    wait_neg(1);
    chk("R10 rx re-allowed", {7'b0, xfer_req_rx}, 8'h01);

    // R11: reset during a held access clears the withdrawal
    bus_mode = 1'b0;
    wait_neg(1);
    chan_ack_n = 1'b0; wr_strobe_n = 1'b0;
    wait_neg(5);
    chk("R11 tx withdrawn before reset", {7'b0, xfer_req_tx}, 8'h00);
    rst_n = 1'b0;
    #1;
    chk("R11 tx restored in reset", {6'b0, mbox_wr, xfer_req_tx}, 8'h01);
    idle();
    wait_neg(2);
    rst_n = 1'b1;
    wait_neg(4);
    chk("R11 quiet after reset", {5'b0, mbox_rd, mbox_wr, xfer_req_tx}, 8'h01);

    finish_run();
  end
endmodule